// File: doc/BRIEF.md
# Flash Hardware-Reset Sequencer

This block sits beside the command engine of a parallel NOR flash model. It turns the active-low hardware reset pin into the internal actions that the pin implies. A low level on the pin counts as a reset only after it has been held for a minimum number of clock cycles. Once a reset counts, the block sends a one-cycle abort to the command engine, which cancels any program or erase in progress and puts the command decoder back into array-read mode.

From the first cycle the pin is low, the block cuts the data-bus output enable and refuses command cycles, whether or not the reset later counts. The recovery that follows depends on whether an embedded operation was running when the reset counted. If one was running, the ready/busy line is held busy for an internal-reset interval. If none was running, ready/busy is not held busy. After the pin goes high again, array reads and commands stay blocked for a read-recovery interval in both cases.

All intervals are cycle counts set by parameters. A generate option adds a synchronizer ahead of the pulse-width check.

Top module: `flash_rst_seq`

## Requirements
- R1: A reset counts only when the pin has been sampled low on `RP_CYC` consecutive rising clock edges. A shorter low pulse causes no abort, no busy interval and no recovery interval.
- R2: `abort_op` is high for exactly one cycle. It rises in the cycle that follows the clock edge on which the reset counted.
- R3: While `hw_rst_n` is low, `dq_oe` and `cmd_ok` are 0 in the same cycle, whatever the enable inputs are.
- R4: `dq_oe` is 0 whenever `chip_en_n` or `out_en_n` is 1.
- R5: When `op_active` is 1 on the edge where the reset counts, `ry_by` is 0 for the `READY_CYC` cycles that follow that edge, then returns to 1.
- R6: When `op_active` is 0 on the edge where the reset counts, `ry_by` stays 1 through the reset and its recovery.
- R7: After the pin is first sampled high following a counted reset, `cmd_ok` and `dq_oe` stay 0 for `RH_CYC` cycles. From the next cycle on, array reads and commands are allowed again.
- R8: In normal operation, `ry_by` is the inverse of `op_active` (0 means busy). `cmd_ok` is 1 and `dq_oe` is the AND of both enables being low.
- R9: After system reset `rst_n`, the block is in normal operation: `abort_op` is 0 and `ry_by` is 1 when `op_active` is 0.
- R10: `cmd_ok` and `dq_oe` also stay 0 until a running internal-reset interval (R5) has ended, even if the read-recovery interval ended earlier.
- R11: A reset that counts while the block is still in read recovery produces a new abort pulse and a new recovery interval.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Active-low system reset of the sequencer |
| hw_rst_n | input | 1 | Device hardware reset pin, active low |
| op_active | input | 1 | Command engine is running a program or erase |
| chip_en_n | input | 1 | Chip enable, active low |
| out_en_n | input | 1 | Output enable, active low |
| ry_by | output | 1 | Ready (1) / busy (0) |
| dq_oe | output | 1 | Data-bus drive enable (0 = high impedance) |
| cmd_ok | output | 1 | Read and write command cycles are accepted |
| abort_op | output | 1 | One-cycle abort to the command engine |

## Verification
A table of one-cycle patterns covers every combination of chip enable, output enable, pin level and engine activity in normal operation, plus isolated one-cycle low pulses on the pin. These patterns separate the combinational gating from the timed recovery. A sub-threshold low pulse with an engine operation running shows that a short pulse neither aborts nor starts recovery. Resets that count with the engine busy and with it idle tell R5 apart from R6 and show whether the read-recovery or the internal-reset interval ends last. A reset repeated inside read recovery shows that qualification restarts.

// File: rtl/flash_rst_pkg.sv
package flash_rst_pkg;

   typedef enum logic [1:0] {
      SEQ_RUN  = 2'd0,
      SEQ_HELD = 2'd1,
      SEQ_REC  = 2'd2
   } seq_state_e;

   function automatic int cnt_width(input int max_val);
      return (max_val < 1) ? 1 : $clog2(max_val + 1);
   endfunction

endpackage

// File: rtl/frs_pin_sync.sv
module frs_pin_sync #(
   parameter int STAGES = 0
) (
   input  logic clk,
   input  logic rst_n,
   input  logic pin_i,
   output logic pin_o
);

   generate
      if (STAGES == 0) begin : g_direct
         assign pin_o = pin_i;
      end else begin : g_chain
         logic [STAGES-1:0] chain_q;
         always_ff @(posedge clk) begin
            if (!rst_n) begin
               chain_q <= '1;
            end else begin
               chain_q <= {chain_q[STAGES-2+((STAGES==1)?1:0):0], pin_i};
            end
         end
         assign pin_o = chain_q[STAGES-1];
      end
   endgenerate

endmodule

// File: rtl/frs_pulse_qual.sv
module frs_pulse_qual
   import flash_rst_pkg::*;
#(
   parameter int MIN_LOW = 3
) (
   input  logic clk,
   input  logic rst_n,
   input  logic pin_s,
   output logic qualify
);

   localparam int LW = cnt_width(MIN_LOW);
   localparam logic [LW-1:0] LIMIT = LW'(MIN_LOW);
   localparam logic [LW-1:0] EDGE  = LW'(MIN_LOW - 1);

   logic [LW-1:0] low_cnt;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         low_cnt <= '0;
      end else if (pin_s) begin
         low_cnt <= '0;
      end else if (low_cnt != LIMIT) begin
         low_cnt <= low_cnt + 1'b1;
      end
   end

   assign qualify = !pin_s && (low_cnt == EDGE);

endmodule

// File: rtl/frs_down_timer.sv
module frs_down_timer
   import flash_rst_pkg::*;
#(
   parameter int LEN = 4
) (
   input  logic clk,
   input  logic rst_n,
   input  logic load,
   output logic running,
   output logic last
);

   localparam int TW = cnt_width(LEN);
   localparam logic [TW-1:0] START = TW'(LEN);

   logic [TW-1:0] cnt;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         cnt <= '0;
      end else if (load) begin
         cnt <= START;
      end else if (cnt != '0) begin
         cnt <= cnt - 1'b1;
      end
   end

   assign running = (cnt != '0);
   assign last    = (cnt == TW'(1));

endmodule

// File: rtl/flash_rst_seq.sv
module flash_rst_seq
   import flash_rst_pkg::*;
#(
   parameter int RP_CYC      = 3,
   parameter int READY_CYC   = 8,
   parameter int RH_CYC      = 4,
   parameter int SYNC_STAGES = 0
) (
   input  logic clk,
   input  logic rst_n,
   input  logic hw_rst_n,
   input  logic op_active,
   input  logic chip_en_n,
   input  logic out_en_n,
   output logic ry_by,
   output logic dq_oe,
   output logic cmd_ok,
   output logic abort_op
);

   generate
      if (RP_CYC < 1) begin : g_bad_rp
         $error("RP_CYC must be at least 1");
      end
      if (READY_CYC < 1) begin : g_bad_ready
         $error("READY_CYC must be at least 1");
      end
      if (RH_CYC < 1) begin : g_bad_rh
         $error("RH_CYC must be at least 1");
      end
      if (SYNC_STAGES < 0) begin : g_bad_sync
         $error("SYNC_STAGES must not be negative");
      end
   endgenerate

   logic       pin_s;
   logic       qualify;
   logic       rdy_running;
   logic       rdy_last;
   logic       rh_running;
   logic       rh_last;
   logic       rh_load;
   logic       abort_q;
   seq_state_e state_q;
   seq_state_e state_d;

   frs_pin_sync #(.STAGES(SYNC_STAGES)) u_sync (
      .clk   (clk),
      .rst_n (rst_n),
      .pin_i (hw_rst_n),
      .pin_o (pin_s)
   );

   frs_pulse_qual #(.MIN_LOW(RP_CYC)) u_qual (
      .clk     (clk),
      .rst_n   (rst_n),
      .pin_s   (pin_s),
      .qualify (qualify)
   );

   // internal-reset interval: only when an embedded operation is cut short
   frs_down_timer #(.LEN(READY_CYC)) u_ready (
      .clk     (clk),
      .rst_n   (rst_n),
      .load    (qualify && op_active),
      .running (rdy_running),
      .last    (rdy_last)
   );

   // read-recovery interval after the pin is released
   frs_down_timer #(.LEN(RH_CYC)) u_recov (
      .clk     (clk),
      .rst_n   (rst_n),
      .load    (rh_load),
      .running (rh_running),
      .last    (rh_last)
   );

   assign rh_load = (state_q == SEQ_HELD) && pin_s;

   always_comb begin
      state_d = state_q;
      unique case (state_q)
         SEQ_RUN: begin
            if (qualify) state_d = SEQ_HELD;
         end
         SEQ_HELD: begin
            if (pin_s) state_d = SEQ_REC;
         end
         SEQ_REC: begin
            if (qualify)      state_d = SEQ_HELD;
            else if (rh_last) state_d = SEQ_RUN;
         end
         default: state_d = SEQ_RUN;
      endcase
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         state_q <= SEQ_RUN;
         abort_q <= 1'b0;
      end else begin
         state_q <= state_d;
         abort_q <= qualify;
      end
   end

   logic array_mode;
   assign array_mode = (state_q == SEQ_RUN) && !rdy_running && hw_rst_n;

   assign abort_op = abort_q;
   assign ry_by    = !rdy_running && !(op_active && (state_q == SEQ_RUN));
   assign cmd_ok   = array_mode;
   assign dq_oe    = array_mode && !chip_en_n && !out_en_n;

   logic unused_ok;
   assign unused_ok = rdy_last ^ rh_running;

endmodule

// File: rtl/frs_checker.sv
module frs_checker #(
   parameter int RP_CYC = 3
) (
   input logic clk,
   input logic rst_n,
   input logic hw_rst_n,
   input logic op_active,
   input logic chip_en_n,
   input logic out_en_n,
   input logic ry_by,
   input logic dq_oe,
   input logic cmd_ok,
   input logic abort_op
);

   p_abort_single_r2: assert property (@(posedge clk) disable iff (!rst_n)
      abort_op |=> !abort_op);

   p_pin_low_gate_r3: assert property (@(posedge clk) disable iff (!rst_n)
      !hw_rst_n |-> (!dq_oe && !cmd_ok));

   p_enable_gate_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (chip_en_n || out_en_n) |-> !dq_oe);

   p_abort_blocks_cmd_r7: assert property (@(posedge clk) disable iff (!rst_n)
      abort_op |-> !cmd_ok);

   p_busy_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (abort_op && $past(op_active)) |-> !ry_by);

   p_no_busy_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (abort_op && !$past(op_active) && !op_active) |-> ry_by);

   p_busy_blocks_cmd_r10: assert property (@(posedge clk) disable iff (!rst_n)
      (!ry_by && !op_active) |-> !cmd_ok);

endmodule

bind flash_rst_seq frs_checker #(.RP_CYC(RP_CYC)) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .hw_rst_n  (hw_rst_n),
   .op_active (op_active),
   .chip_en_n (chip_en_n),
   .out_en_n  (out_en_n),
   .ry_by     (ry_by),
   .dq_oe     (dq_oe),
   .cmd_ok    (cmd_ok),
   .abort_op  (abort_op)
);

// File: tb/sim_flash_rst_seq.sv
module sim_flash_rst_seq;

   localparam int RP  = 3;
   localparam int RDY = 8;
   localparam int RH  = 4;

   logic clk = 1'b0;
   logic rst_n, hw_rst_n, op_active, chip_en_n, out_en_n;
   logic ry_by, dq_oe, cmd_ok, abort_op;
   int   n_chk = 0;
   int   n_err = 0;
   bit   done  = 0;

   always #2 clk = ~clk;

   flash_rst_seq #(.RP_CYC(RP), .READY_CYC(RDY), .RH_CYC(RH), .SYNC_STAGES(0)) u0 (
      .clk(clk), .rst_n(rst_n), .hw_rst_n(hw_rst_n), .op_active(op_active),
      .chip_en_n(chip_en_n), .out_en_n(out_en_n),
      .ry_by(ry_by), .dq_oe(dq_oe), .cmd_ok(cmd_ok), .abort_op(abort_op)
   );

   // bits: ce_n oe_n pin op | dq_oe ry_by cmd_ok
   localparam logic [6:0] VEC [0:7] = '{
      7'b0010_111, 7'b0110_011, 7'b1010_011, 7'b0000_010,
      7'b0011_101, 7'b0001_000, 7'b1111_001, 7'b0010_111
   };

   task automatic chk(input bit ok, input string tag, input int act, input int exp);
      n_chk++;
      if (!ok) begin
         n_err++;
         $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
      end
   endtask

   task automatic chk3(input string tag, input logic e_oe, input logic e_ry, input logic e_cmd);
      chk(dq_oe == e_oe, {tag, " dq_oe"}, dq_oe, e_oe);
      chk(ry_by == e_ry, {tag, " ry_by"}, ry_by, e_ry);
      chk(cmd_ok == e_cmd, {tag, " cmd_ok"}, cmd_ok, e_cmd);
   endtask

   task automatic tick();
      @(posedge clk);
      #1;
   endtask

   initial begin
      repeat (20000) @(posedge clk);
      if (!done) begin
         n_err++;
         n_chk++;
         $display("FAIL watchdog actual=1 expected=0");
         $display("Result: errors=%0d of %0d checks", n_err, n_chk);
         $finish;
      end
   end

   initial begin
      rst_n = 0; hw_rst_n = 1; op_active = 0; chip_en_n = 0; out_en_n = 0;
      repeat (3) tick();
      rst_n = 1;
      tick();
      // R9 reset state
      chk(abort_op == 0, "R9 abort", abort_op, 0);
      chk3("R9", 1, 1, 1);

      // R8 / R3 / R4 table
      foreach (VEC[i]) begin
         {chip_en_n, out_en_n, hw_rst_n, op_active} = VEC[i][6:3];
         #1;
         chk3($sformatf("R8/R3/R4 vec%0d", i), VEC[i][2], VEC[i][1], VEC[i][0]);
         tick();
      end
      hw_rst_n = 1; op_active = 0; chip_en_n = 0; out_en_n = 0;
      tick();

      // R1 short pulse with operation running
      op_active = 1;
      hw_rst_n = 0;
      for (int k = 0; k < RP - 1; k++) begin
         tick();
         chk(abort_op == 0, "R1 short abort", abort_op, 0);
      end
      hw_rst_n = 1;
      #1;
      chk3("R1 short no recovery", 1, 0, 1);
      tick();
      chk(abort_op == 0, "R1 short abort after", abort_op, 0);
      chk3("R1 short after", 1, 0, 1);
      op_active = 0;
      tick();

      // R5/R10/R2: reset during an embedded operation
      op_active = 1;
      hw_rst_n = 0;
      tick(); tick();
      chk(abort_op == 0, "R1 before qualify", abort_op, 0);
      tick();
      chk(abort_op == 1, "R2 abort rises", abort_op, 1);
      chk(ry_by == 0, "R5 busy at abort", ry_by, 0);
      op_active = 0;
      tick();
      chk(abort_op == 0, "R2 abort single", abort_op, 0);
      chk(ry_by == 0, "R5 busy held", ry_by, 0);
      hw_rst_n = 1;
      for (int k = 5; k <= 11; k++) begin
         tick();
         chk(ry_by == (k >= 11), $sformatf("R5 ry_by edge%0d", k), ry_by, k >= 11);
         chk(cmd_ok == (k >= 11), $sformatf("R10 cmd_ok edge%0d", k), cmd_ok, k >= 11);
         chk(dq_oe == (k >= 11), $sformatf("R10 dq_oe edge%0d", k), dq_oe, k >= 11);
      end

      // R6/R7: reset with no operation running
      hw_rst_n = 0;
      tick(); tick(); tick();
      chk(abort_op == 1, "R2 idle abort", abort_op, 1);
      chk(ry_by == 1, "R6 ready at abort", ry_by, 1);
      tick(); tick(); tick();
      chk(ry_by == 1, "R6 ready while held", ry_by, 1);
      chk3("R3 held", 0, 1, 0);
      hw_rst_n = 1;
      for (int k = 1; k <= 5; k++) begin
         tick();
         chk(ry_by == 1, $sformatf("R6 ready rec%0d", k), ry_by, 1);
         chk(cmd_ok == (k >= 5), $sformatf("R7 cmd_ok rec%0d", k), cmd_ok, k >= 5);
         chk(dq_oe == (k >= 5), $sformatf("R7 dq_oe rec%0d", k), dq_oe, k >= 5);
      end

      // R11: reset again during read recovery
      hw_rst_n = 0;
      tick(); tick(); tick();
      chk(abort_op == 1, "R11 first abort", abort_op, 1);
      hw_rst_n = 1;
      tick();
      tick();
      chk(cmd_ok == 0, "R11 in recovery", cmd_ok, 0);
      hw_rst_n = 0;
      tick(); tick();
      chk(abort_op == 0, "R11 not yet", abort_op, 0);
      tick();
      chk(abort_op == 1, "R11 second abort", abort_op, 1);
      hw_rst_n = 1;
      for (int k = 1; k <= 5; k++) begin
         tick();
         chk(cmd_ok == (k >= 5), $sformatf("R11 cmd_ok rec%0d", k), cmd_ok, k >= 5);
      end
      out_en_n = 1;
      #1;
      chk(dq_oe == 0, "R4 out_en high", dq_oe, 0);

      done = 1;
      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
   end

endmodule